// File: doc/BRIEF.md
# Fixed-Point Rounder with Run-Time Tie Policy

This block narrows a signed two's-complement word by removing a fixed count of low-order fraction bits. The kept bits form the result. In its round-to-nearest modes a value whose removed fraction is more than half goes up, and a value whose removed fraction is less than half goes down. A sample that sits exactly halfway is settled by a policy chosen per sample on the `mode` input. The policy can pick the even neighbour, alternate direction from one tie to the next, or follow an externally supplied `tie_bit`. Two directed modes, toward zero and away from zero, are also available.

Each sample is qualified by `in_valid` and appears on the output one clock later together with `out_valid`. Rounding up from the largest positive kept value would wrap, so the result saturates there instead. A tie is a sample whose highest removed bit is 1 and whose other removed bits are all 0.

Top module: `sym_rounder`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, and the alternating direction is set to round-up.
- R2: `mode` is 3 bits with these codes: 0 ties-to-even, 1 alternating, 2 external tie bit, 3 toward zero, 4 away from zero. Codes 5 to 7 act as code 0. In every mode, an input whose removed bits are all zero passes its kept bits through unchanged.
- R3: In codes 0, 1 and 2, a non-tie sample rounds up when the removed fraction exceeds one half and down when it is below one half. The output is always the floor of the input, or the floor plus one.
- R4: In code 0, a tie resolves to whichever neighbour has kept LSB 0.
- R5: In code 1, the first tie after reset rounds up. Each later valid tie in code 1 goes the opposite way from the previous one.
- R6: In code 2, a tie rounds up when `tie_bit` is 1 and down when it is 0.
- R7: In code 3, a negative input with a nonzero removed fraction rounds up (toward zero). All other inputs are truncated.
- R8: In code 4, a non-negative input with a nonzero removed fraction rounds up. All other inputs are truncated.
- R9: A round-up from the largest positive kept value yields that largest value (saturation).
- R10: `out_valid` equals `in_valid` delayed by one cycle. Without a valid input, `out_data` holds its value.
- R11: The alternating direction changes only on valid ties in code 1. Invalid samples, non-ties and ties in other codes leave it unchanged.
- R12: In code 0, over the symmetric ramp -1000..+1000 the summed rounding error is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Signed input word |
| mode | input | 3 | Rounding mode code |
| tie_bit | input | 1 | Tie direction in code 2 (1 up, 0 down) |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | IN_W-DROP | Signed rounded result |

## Verification
The assertions check the following on every cycle: the one-cycle valid latency and the hold of idle output, that each result is the floor or the floor plus one, pass-through of exact values, saturation at the top, and that the alternating state flips only on valid ties in code 1. The exact choice between the two neighbours, in each mode and for every input, is shown only by the bench's sweeps against its reference model. The same is true of the order of alternating ties and the zero-bias property of ties-to-even.

// File: rtl/sym_rounder.sv
module sym_rounder #(
  parameter int IN_W = 12,
  parameter int DROP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      in_data,
  input  logic [2:0]           mode,
  input  logic                 tie_bit,
  output logic                 out_valid,
  output logic [IN_W-DROP-1:0] out_data
);
  localparam int OUT_W = IN_W - DROP;
  localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] kept;
  logic [DROP-1:0]  frac;
  logic half, rest, tie, nonzero, neg;
  logic tie_up, carry, sat, alt_up;

  assign kept    = in_data[IN_W-1:DROP];
  assign frac    = in_data[DROP-1:0];
  assign half    = frac[DROP-1];
  assign rest    = |frac[DROP-2:0];
  assign tie     = half & ~rest;
  assign nonzero = |frac;
  assign neg     = in_data[IN_W-1];

  always_comb begin
    case (mode)
      3'd1:    tie_up = alt_up;
      3'd2:    tie_up = tie_bit;
      default: tie_up = kept[0];
    endcase
  end

  always_comb begin
    case (mode)
      3'd3:    carry = neg & nonzero;
      3'd4:    carry = ~neg & nonzero;
      default: carry = tie ? tie_up : half;
    endcase
  end

  assign sat = carry & (kept == MAX_POS);

  always_ff @(posedge clk) begin
    if (!rst_n)
      alt_up <= 1'b1;
    else if (in_valid && mode == 3'd1 && tie)
      alt_up <= ~alt_up;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= sat ? kept : kept + OUT_W'(carry);
    end
  end
endmodule

// File: rtl/sym_rounder_chk.sv
module sym_rounder_chk #(
  parameter int IN_W = 12,
  parameter int DROP = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [IN_W-1:0]      in_data,
  input logic [2:0]           mode,
  input logic                 out_valid,
  input logic [IN_W-DROP-1:0] out_data,
  input logic                 alt_up
);
  localparam int OUT_W = IN_W - DROP;
  localparam logic [OUT_W-1:0] TOP = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] kept_in, kept_inc;
  logic is_tie, exact, alt_tie;

  assign kept_in  = in_data[IN_W-1:DROP];
  assign kept_inc = kept_in + 1'b1;
  assign exact    = (in_data[DROP-1:0] == '0);
  assign is_tie   = (in_data[DROP-1:0] == {1'b1, {(DROP-1){1'b0}}});
  assign alt_tie  = in_valid && (mode == 3'd1) && is_tie;

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));
  assert_neighbour_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data == $past(kept_in) || out_data == $past(kept_inc)));
  assert_exact_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && exact) |=> out_data == $past(kept_in));
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kept_in == TOP) |=> out_data == TOP);
  assert_alt_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alt_tie |=> alt_up != $past(alt_up));
  assert_alt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_tie |=> $stable(alt_up));
endmodule

bind sym_rounder sym_rounder_chk #(.IN_W(IN_W), .DROP(DROP)) u_chk (.*);

// File: tb/tb_sym_rounder.sv
`timescale 1ns/1ps
module tb_sym_rounder;
  localparam int IN_W = 12;
  localparam int DROP = 4;
  localparam int OUT_W = IN_W - DROP;
  localparam int SCALE = 1 << DROP;
  localparam int HALF = SCALE / 2;
  localparam int MAXV = (1 << (OUT_W-1)) - 1;

  logic clk = 0, rst_n = 0, in_valid = 0, tie_bit = 0;
  logic [IN_W-1:0] in_data = '0;
  logic [2:0] mode = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_data;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sym_rounder #(.IN_W(IN_W), .DROP(DROP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .mode(mode), .tie_bit(tie_bit), .out_valid(out_valid), .out_data(out_data));

  task automatic check(bit ok, string rq, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int floor_div(int x);
    return x >>> DROP;
  endfunction

  function automatic int model(int x, int m, bit tb, bit alt);
    int k = floor_div(x);
    int f = x - k * SCALE;
    int up = 0;
    int r;
    if (m >= 5) m = 0;
    if (m == 3) up = (x < 0 && f != 0) ? 1 : 0;
    else if (m == 4) up = (x >= 0 && f != 0) ? 1 : 0;
    else if (f > HALF) up = 1;
    else if (f < HALF) up = 0;
    else if (m == 0) up = (k % 2 != 0) ? 1 : 0;
    else if (m == 1) up = alt ? 1 : 0;
    else up = tb ? 1 : 0;
    r = k + up;
    if (r > MAXV) r = MAXV;
    return r;
  endfunction

  function automatic int sout();
    return int'($signed(out_data));
  endfunction

  task automatic do_reset();
    in_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    check(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    check(out_data == 0, "R1 out_data", sout(), 0);
  endtask

  // exhaustive sweep of one mode against the model
  task automatic t_sweep(int m, string rq);
    bit alt = 1;
    int errs = 0, bad_a = 0, bad_e = 0, expv = 0;
    do_reset();
    for (int i = -(1 << (IN_W-1)); i <= (1 << (IN_W-1)); i++) begin
      @(negedge clk);
      if (i > -(1 << (IN_W-1))) begin
        if (!out_valid || sout() != expv) begin
          if (errs == 0) begin bad_a = sout(); bad_e = expv; end
          errs++;
        end
      end
      if (i < (1 << (IN_W-1))) begin
        bit tb = i[5] ^ i[0] ^ i[8];
        in_valid = 1;
        in_data = i[IN_W-1:0];
        mode = m[2:0];
        tie_bit = tb;
        expv = model(i, m, tb, alt);
        if (m == 1 && (i - floor_div(i) * SCALE) == HALF) alt = ~alt;
      end else
        in_valid = 0;
    end
    check(errs == 0, rq, bad_a, bad_e);
  endtask

  task automatic t_saturate();
    do_reset();
    @(negedge clk);
    in_valid = 1; mode = 3'd0; in_data = 12'h7F8;
    @(negedge clk);
    check(sout() == MAXV, "R9 tie at top", sout(), MAXV);
    mode = 3'd4; in_data = 12'h7F1;
    @(negedge clk);
    check(sout() == MAXV, "R9 away-from-zero at top", sout(), MAXV);
    in_valid = 0;
  endtask

  task automatic t_valid_and_alt();
    int held;
    do_reset();
    @(negedge clk);
    in_valid = 1; mode = 3'd1; in_data = 12'h018;
    @(negedge clk);
    check(sout() == 2, "R5 first alternating tie up", sout(), 2);
    held = sout();
    in_valid = 0; in_data = 12'h028;
    @(negedge clk);
    in_data = 12'h038;
    @(negedge clk);
    check(out_valid == 0, "R10 out_valid low when idle", int'(out_valid), 0);
    check(sout() == held, "R10 output held when idle", sout(), held);
    in_valid = 1; in_data = 12'h019;
    @(negedge clk);
    mode = 3'd0; in_data = 12'h018;
    @(negedge clk);
    mode = 3'd1; in_data = 12'h018;
    @(negedge clk);
    check(sout() == 1, "R11 alternating state untouched by other samples", sout(), 1);
    in_data = 12'h018;
    @(negedge clk);
    check(sout() == 2, "R5 third alternating tie up", sout(), 2);
    in_valid = 0;
  endtask

  task automatic t_zero_mean();
    int acc = 0;
    do_reset();
    for (int x = -1000; x <= 1001; x++) begin
      @(negedge clk);
      if (x > -1000) acc += sout() * SCALE - (x - 1);
      if (x <= 1000) begin
        in_valid = 1; mode = 3'd0; in_data = x[IN_W-1:0];
      end else in_valid = 0;
    end
    check(acc == 0, "R12 ties-to-even zero mean", acc, 0);
  endtask

  initial begin
    #700000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep(0, "R4 R3 R2 ties-to-even sweep");
    t_sweep(1, "R5 alternating sweep");
    t_sweep(2, "R6 external tie bit sweep");
    t_sweep(3, "R7 toward zero sweep");
    t_sweep(4, "R8 away from zero sweep");
    t_sweep(7, "R2 code 7 acts as ties-to-even");
    t_saturate();
    t_valid_and_alt();
    t_zero_mean();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule